// File: doc/BRIEF.md
# Windowed Multithreaded Register File

This block is the integer register store for a core that interleaves four hardware threads. Each thread owns its own copy of a set of overlapping register windows. A 5-bit register number is translated to a physical entry through that thread's current window pointer. Numbers 0–7 are globals that every window of the thread shares. Numbers 8–15 are the outs, 16–23 the locals and 24–31 the ins. The outs of window w are physically the ins of window w+1, so a callee sees its caller's outgoing arguments without any copying.

Every access port carries its own thread identifier. There are two read ports and one write port. A separate window-operation input moves one thread's pointer each cycle. The pointer has three transitions: save (w to w+1 modulo the window count), restore (w to w−1 modulo the window count) and hold. Reads are registered: the address is presented in one cycle and the data appears after the next clock edge. A write lands at that same edge. Overflow and underflow traps, and bypassing, belong to the surrounding pipeline.

Top module: `windowed_rf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both read outputs are zero. Every thread's window pointer returns to window 0.
- R2: The read data for a thread and register presented in a cycle appears on that port's output after the next rising clock edge. A write presented in a cycle is stored at that edge.
- R3: Register 0 always reads as zero. A write to register 0 has no effect on any entry.
- R4: Registers 1–7 of a thread refer to the same entries whatever that thread's window pointer is.
- R5: Registers 16–23 (locals) are private to each window. A value written in one window is not seen in another.
- R6: Register 8+k (out k) in window w is the same entry as register 24+k (in k) in window (w+1) mod 8, for k in 0–7. This includes the wrap from window 7 to window 0.
- R7: Threads are independent. The same register number in different threads refers to different entries, and each thread has its own window pointer.
- R8: The window operation is encoded as 2'b01 = save (the pointer of win_tid increments), 2'b10 = restore (it decrements), and 2'b00 or 2'b11 = hold. A pointer change takes effect for accesses in the following cycle. Accesses in the same cycle as the operation still use the old window.
- R9: Pointer arithmetic wraps modulo 8. Eight saves return a thread to its starting window, and a restore from window 0 goes to window 7.
- R10: A read and a write of the same physical entry in the same cycle return the old value. The new value is read in later cycles.
- R11: The two read ports are independent. Each uses its own thread identifier, and they return identical data when given the same thread and register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_op | input | 2 | Window operation: 00 hold, 01 save, 10 restore, 11 hold |
| win_tid | input | 2 | Thread whose window pointer win_op acts on |
| wr_en | input | 1 | Write enable |
| wr_tid | input | 2 | Thread of the write |
| wr_reg | input | 5 | Architectural register number of the write |
| wr_data | input | 32 | Write data |
| ra_tid | input | 2 | Thread of read port A |
| ra_reg | input | 5 | Register number of read port A |
| ra_data | output | 32 | Registered read data of port A |
| rb_tid | input | 2 | Thread of read port B |
| rb_reg | input | 5 | Register number of read port B |
| rb_data | output | 32 | Registered read data of port B |

## Verification
Some rules are checked by assertions on every cycle: register 0 reads back as zero on both ports, the two ports agree when they are given the same address, and each window pointer takes exactly the save, restore or hold step it was asked for. Other behaviour depends on what was written earlier, and only the bench's scenarios can show it. This covers the sharing of outs with the next window's ins (including across the 7-to-0 boundary), the privacy of locals, the separation of threads, read-before-write ordering within a cycle, and the full eight-step wrap of a pointer.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Register group, taken from the two upper bits of the register number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'b00,
        GRP_OUT    = 2'b01,
        GRP_LOCAL  = 2'b10,
        GRP_IN     = 2'b11
    } reg_grp_e;

    // Window pointer operation
    typedef enum logic [1:0] {
        WOP_HOLD    = 2'b00,
        WOP_SAVE    = 2'b01,
        WOP_RESTORE = 2'b10,
        WOP_HOLD_X  = 2'b11
    } win_op_e;

    // Registers in each group, fixed by the 5-bit register number
    localparam int GRP_SIZE = 8;

endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_WIN     = 8,
    parameter int TID_W       = 2,
    parameter int WP_W        = 3,
    parameter int PA_W        = 10
) (
    input  logic [TID_W-1:0] tid,
    input  logic [4:0]       reg_num,
    input  logic [WP_W-1:0]  cwp,
    output logic [PA_W-1:0]  phys_idx,
    output logic             is_zero
);
    import rf_pkg::*;

    // Each window owns locals then ins; outs live in the next window's ins
    localparam int WIN_SPAN = 2 * GRP_SIZE;
    localparam int STRIDE   = GRP_SIZE + NUM_WIN * WIN_SPAN;

    reg_grp_e        grp;
    logic [WP_W-1:0] next_win;
    int              slot;
    int              loc;

    always_comb begin
        grp      = reg_grp_e'(reg_num[4:3]);
        slot     = int'(reg_num[2:0]);
        next_win = (cwp == WP_W'(NUM_WIN - 1)) ? '0 : cwp + 1'b1;
        unique case (grp)
            GRP_GLOBAL: loc = slot;
            GRP_OUT:    loc = GRP_SIZE + int'(next_win) * WIN_SPAN + GRP_SIZE + slot;
            GRP_LOCAL:  loc = GRP_SIZE + int'(cwp) * WIN_SPAN + slot;
            GRP_IN:     loc = GRP_SIZE + int'(cwp) * WIN_SPAN + GRP_SIZE + slot;
            default:    loc = slot;
        endcase
        phys_idx = PA_W'(int'(tid) * STRIDE + loc);
        is_zero  = (reg_num == 5'd0);
    end

endmodule

// File: rtl/rf_win_ptr.sv
module rf_win_ptr #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_WIN     = 8,
    parameter int TID_W       = 2,
    parameter int WP_W        = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       win_op,
    input  logic [TID_W-1:0]                 win_tid,
    output logic [NUM_THREADS-1:0][WP_W-1:0] cwp
);
    import rf_pkg::*;

    localparam logic [WP_W-1:0] LAST_WIN = WP_W'(NUM_WIN - 1);

    win_op_e op;

    always_comb op = win_op_e'(win_op);

    // Pointer register: one step per cycle for the selected thread
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cwp <= '0;
        end else begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (win_tid == TID_W'(t)) begin
                    unique case (op)
                        WOP_SAVE:    cwp[t] <= (cwp[t] == LAST_WIN) ? '0 : cwp[t] + 1'b1;
                        WOP_RESTORE: cwp[t] <= (cwp[t] == '0) ? LAST_WIN : cwp[t] - 1'b1;
                        WOP_HOLD,
                        WOP_HOLD_X:  cwp[t] <= cwp[t];
                        default:     cwp[t] <= cwp[t];
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DEPTH  = 544,
    parameter int PA_W   = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PA_W-1:0]   w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [PA_W-1:0]   a_idx,
    input  logic              a_zero,
    input  logic [PA_W-1:0]   b_idx,
    input  logic              b_zero,
    output logic [DATA_W-1:0] a_data,
    output logic [DATA_W-1:0] b_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[w_idx] <= w_data;
        end
    end

    // Registered reads capture the pre-write contents of the array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_data <= '0;
            b_data <= '0;
        end else begin
            a_data <= a_zero ? '0 : mem[a_idx];
            b_data <= b_zero ? '0 : mem[b_idx];
        end
    end

endmodule

// File: rtl/windowed_rf.sv
module windowed_rf #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_WIN     = 8,
    parameter int DATA_W      = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     win_op,
    input  logic [$clog2(NUM_THREADS)-1:0] win_tid,
    input  logic                           wr_en,
    input  logic [$clog2(NUM_THREADS)-1:0] wr_tid,
    input  logic [4:0]                     wr_reg,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [$clog2(NUM_THREADS)-1:0] ra_tid,
    input  logic [4:0]                     ra_reg,
    output logic [DATA_W-1:0]              ra_data,
    input  logic [$clog2(NUM_THREADS)-1:0] rb_tid,
    input  logic [4:0]                     rb_reg,
    output logic [DATA_W-1:0]              rb_data
);
    import rf_pkg::*;

    localparam int TID_W  = $clog2(NUM_THREADS);
    localparam int WP_W   = $clog2(NUM_WIN);
    localparam int STRIDE = GRP_SIZE + NUM_WIN * 2 * GRP_SIZE;
    localparam int DEPTH  = NUM_THREADS * STRIDE;
    localparam int PA_W   = $clog2(DEPTH);
    localparam int N_PORT = 3;   // 0 = write, 1 = read A, 2 = read B

    logic [NUM_THREADS-1:0][WP_W-1:0] cwp;
    logic [TID_W-1:0] p_tid  [N_PORT];
    logic [4:0]       p_reg  [N_PORT];
    logic [PA_W-1:0]  p_idx  [N_PORT];
    logic             p_zero [N_PORT];

    assign p_tid[0] = wr_tid;
    assign p_reg[0] = wr_reg;
    assign p_tid[1] = ra_tid;
    assign p_reg[1] = ra_reg;
    assign p_tid[2] = rb_tid;
    assign p_reg[2] = rb_reg;

    rf_win_ptr #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_WIN     (NUM_WIN),
        .TID_W       (TID_W),
        .WP_W        (WP_W)
    ) u_win_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_op  (win_op),
        .win_tid (win_tid),
        .cwp     (cwp)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        rf_addr_map #(
            .NUM_THREADS (NUM_THREADS),
            .NUM_WIN     (NUM_WIN),
            .TID_W       (TID_W),
            .WP_W        (WP_W),
            .PA_W        (PA_W)
        ) u_map (
            .tid      (p_tid[p]),
            .reg_num  (p_reg[p]),
            .cwp      (cwp[p_tid[p]]),
            .phys_idx (p_idx[p]),
            .is_zero  (p_zero[p])
        );
    end

    rf_storage #(
        .DEPTH  (DEPTH),
        .PA_W   (PA_W),
        .DATA_W (DATA_W)
    ) u_storage (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en & ~p_zero[0]),
        .w_idx  (p_idx[0]),
        .w_data (wr_data),
        .a_idx  (p_idx[1]),
        .a_zero (p_zero[1]),
        .b_idx  (p_idx[2]),
        .b_zero (p_zero[2]),
        .a_data (ra_data),
        .b_data (rb_data)
    );

endmodule

// File: rtl/windowed_rf_chk.sv
module windowed_rf_chk #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_WIN     = 8,
    parameter int DATA_W      = 32
) (
    input logic                                               clk,
    input logic                                               rst_n,
    input logic [1:0]                                         win_op,
    input logic [$clog2(NUM_THREADS)-1:0]                     win_tid,
    input logic [$clog2(NUM_THREADS)-1:0]                     ra_tid,
    input logic [4:0]                                         ra_reg,
    input logic [DATA_W-1:0]                                  ra_data,
    input logic [$clog2(NUM_THREADS)-1:0]                     rb_tid,
    input logic [4:0]                                         rb_reg,
    input logic [DATA_W-1:0]                                  rb_data,
    input logic [NUM_THREADS-1:0][$clog2(NUM_WIN)-1:0]        cwp
);
    localparam int TID_W = $clog2(NUM_THREADS);
    localparam int WP_W  = $clog2(NUM_WIN);

    logic [TID_W-1:0] tid_q;
    logic [WP_W-1:0]  cur_ptr, now_ptr, up_ptr, dn_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tid_q <= '0;
        else        tid_q <= win_tid;
    end

    always_comb begin
        cur_ptr = cwp[win_tid];
        now_ptr = cwp[tid_q];
        up_ptr  = (cur_ptr == WP_W'(NUM_WIN - 1)) ? '0 : cur_ptr + 1'b1;
        dn_ptr  = (cur_ptr == '0) ? WP_W'(NUM_WIN - 1) : cur_ptr - 1'b1;
    end

    // R3
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_reg == 5'd0) |=> (ra_data == '0));

    // R3
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_reg == 5'd0) |=> (rb_data == '0));

    // R11
    port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ra_tid == rb_tid) && (ra_reg == rb_reg)) |=> (ra_data == rb_data));

    // R8
    save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == 2'b01) |=> (now_ptr == $past(up_ptr)));

    // R8
    restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == 2'b10) |=> (now_ptr == $past(dn_ptr)));

    // R8
    hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_op == 2'b00) || (win_op == 2'b11)) |=> $stable(cwp));

endmodule

bind windowed_rf windowed_rf_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_WIN     (NUM_WIN),
    .DATA_W      (DATA_W)
) u_windowed_rf_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_op  (win_op),
    .win_tid (win_tid),
    .ra_tid  (ra_tid),
    .ra_reg  (ra_reg),
    .ra_data (ra_data),
    .rb_tid  (rb_tid),
    .rb_reg  (rb_reg),
    .rb_data (rb_data),
    .cwp     (cwp)
);

// File: tb/test_windowed_rf.sv
module test_windowed_rf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  win_op = '0;
    logic [1:0]  win_tid = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_tid = '0;
    logic [4:0]  wr_reg = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ra_tid = '0;
    logic [4:0]  ra_reg = '0;
    logic [31:0] ra_data;
    logic [1:0]  rb_tid = '0;
    logic [4:0]  rb_reg = '0;
    logic [31:0] rb_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    windowed_rf i_windowed_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_op  (win_op),
        .win_tid (win_tid),
        .wr_en   (wr_en),
        .wr_tid  (wr_tid),
        .wr_reg  (wr_reg),
        .wr_data (wr_data),
        .ra_tid  (ra_tid),
        .ra_reg  (ra_reg),
        .ra_data (ra_data),
        .rb_tid  (rb_tid),
        .rb_reg  (rb_reg),
        .rb_data (rb_data)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  op_t;
        logic        we;
        logic [1:0]  w_t;
        logic [4:0]  w_r;
        logic [31:0] w_d;
        logic [1:0]  a_t;
        logic [4:0]  a_r;
        logic [1:0]  b_t;
        logic [4:0]  b_r;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [7:0]  rq;
    } vec_t;

    function automatic vec_t mk(int op, int opt, int we, int wt, int wr, int wd,
                                int at, int ar, int bt, int br, int ea, int eb, int rq);
        vec_t v;
        v.op = 2'(op);  v.op_t = 2'(opt); v.we = 1'(we);
        v.w_t = 2'(wt); v.w_r = 5'(wr);   v.w_d = 32'(wd);
        v.a_t = 2'(at); v.a_r = 5'(ar);   v.b_t = 2'(bt); v.b_r = 5'(br);
        v.ea = 32'(ea); v.eb = 32'(eb);   v.rq = 8'(rq);
        return v;
    endfunction

    localparam int NV = 22;
    // op op_t we w_t w_r w_d | a_t a_r b_t b_r | exp_a exp_b | requirement
    localparam vec_t VEC [NV] = '{
        mk(0,0,1,0, 1,'h11,   0, 0, 0, 0, 0,      0,      3),  // R3 r0 reads zero
        mk(0,0,1,0,16,'h160,  0, 1, 1, 0, 'h11,   0,      4),  // R4 global
        mk(0,0,1,0, 8,'h80,   0,16, 0, 0, 'h160,  0,      2),  // R2 one-cycle read
        mk(0,0,1,0, 0,'hDEAD, 0, 8, 0, 0, 'h80,   0,      3),  // R3 write r0
        mk(0,0,1,1,16,'h1160, 0,16, 0, 1, 'h160,  'h11,   7),  // R7 thread 1 local
        mk(1,0,1,0,17,'h171,  1,16, 0, 8, 'h1160, 'h80,   8),  // R8 save, old window still used
        mk(0,0,1,0,16,'h261,  0,24, 0, 1, 'h80,   'h11,   6),  // R6 in = caller out
        mk(0,0,1,0, 9,'h91,   0,16, 1,16, 'h261,  'h1160, 5),  // R5 local of window 1
        mk(2,0,0,0, 0,0,      0,16, 0,24, 'h261,  'h80,   8),  // R8 restore, same-cycle
        mk(0,0,0,0, 0,0,      0,16, 0,17, 'h160,  'h171,  5),  // R5 window 0 locals intact
        mk(0,0,1,0,16,'h999,  0,16, 0, 8, 'h160,  'h80,   10), // R10 read old value
        mk(0,0,0,0, 0,0,      0,16, 0, 0, 'h999,  0,      10), // R10 new value, R3 r0
        mk(2,0,0,0, 0,0,      0,16, 0, 1, 'h999,  'h11,   9),  // R9 restore 0 -> 7
        mk(0,0,1,0, 8,'h7808, 0, 1, 1, 0, 'h11,   0,      9),  // R9 out of window 7
        mk(1,0,0,0, 0,0,      0, 8, 0, 0, 'h7808, 0,      9),  // R9 save 7 -> 0
        mk(0,0,0,0, 0,0,      0,24, 0,16, 'h7808, 'h999,  6),  // R6 wrap share
        mk(3,0,0,0, 0,0,      0,16, 0, 0, 'h999,  0,      8),  // R8 code 11 holds
        mk(0,0,0,0, 0,0,      0,16, 0,24, 'h999,  'h7808, 8),  // R8 still window 0
        mk(1,1,0,0, 0,0,      0,16, 1,16, 'h999,  'h1160, 11), // R11 ports on two threads
        mk(0,0,1,1,16,'h1261, 0,16, 0,24, 'h999,  'h7808, 7),  // R7 thread 0 not moved
        mk(2,1,0,0, 0,0,      1,16, 0,16, 'h1261, 'h999,  7),  // R7 thread 1 window 1
        mk(0,0,0,0, 0,0,      1,16, 0, 1, 'h1160, 'h11,   7)   // R7 thread 1 back at 0
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        win_op = 2'b00; win_tid = 2'd0; wr_en = 1'b0;
        wr_tid = 2'd0;  wr_reg = 5'd0;  wr_data = '0;
        ra_tid = 2'd0;  ra_reg = 5'd0;  rb_tid = 2'd0; rb_reg = 5'd0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        idle();
        // R1: outputs zero during reset
        repeat (3) @(posedge clk);
        #1;
        check("R1 port A in reset", ra_data, 32'h0);
        check("R1 port B in reset", rb_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            win_op = VEC[i].op;  win_tid = VEC[i].op_t;
            wr_en  = VEC[i].we;  wr_tid  = VEC[i].w_t;
            wr_reg = VEC[i].w_r; wr_data = VEC[i].w_d;
            ra_tid = VEC[i].a_t; ra_reg  = VEC[i].a_r;
            rb_tid = VEC[i].b_t; rb_reg  = VEC[i].b_r;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vector %0d port A", VEC[i].rq, i), ra_data, VEC[i].ea);
            check($sformatf("R%0d vector %0d port B", VEC[i].rq, i), rb_data, VEC[i].eb);
            @(negedge clk);
        end
        idle();

        // R9: eight saves return thread 2 to its window
        wr_en = 1'b1; wr_tid = 2'd2; wr_reg = 5'd16; wr_data = 32'hABC;
        cyc();
        idle();
        for (int k = 0; k < 4; k++) begin
            win_op = 2'b01; win_tid = 2'd2;
            cyc();
        end
        idle();
        wr_en = 1'b1; wr_tid = 2'd2; wr_reg = 5'd16; wr_data = 32'h444;
        cyc();
        idle();
        for (int k = 0; k < 4; k++) begin
            win_op = 2'b01; win_tid = 2'd2;
            cyc();
        end
        idle();
        ra_tid = 2'd2; ra_reg = 5'd16;
        @(posedge clk);
        #1;
        check("R9 eight saves wrap", ra_data, 32'hABC);
        @(negedge clk);
        idle();
        for (int k = 0; k < 4; k++) begin
            win_op = 2'b10; win_tid = 2'd2;
            cyc();
        end
        idle();
        ra_tid = 2'd2; ra_reg = 5'd16;
        @(posedge clk);
        #1;
        check("R9 four restores reach window 4", ra_data, 32'h444);
        @(negedge clk);
        idle();

        // R1: reset returns pointers to window 0
        win_op = 2'b01; win_tid = 2'd3;
        cyc();
        idle();
        wr_en = 1'b1; wr_tid = 2'd3; wr_reg = 5'd16; wr_data = 32'h3316;
        cyc();
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 port A after reset", ra_data, 32'h0);
        check("R1 port B after reset", rb_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b1; wr_tid = 2'd3; wr_reg = 5'd8; wr_data = 32'h3308;
        cyc();
        idle();
        win_op = 2'b01; win_tid = 2'd3;
        cyc();
        idle();
        ra_tid = 2'd3; ra_reg = 5'd24; rb_tid = 2'd3; rb_reg = 5'd16;
        @(posedge clk);
        #1;
        check("R1 pointer reset, in of window 1", ra_data, 32'h3308);
        check("R1 pointer reset, local of window 1", rb_data, 32'h3316);
        @(negedge clk);
        idle();

        done = 1'b1;
        finish_run();
    end

endmodule